// File: doc/BRIEF.md
# Bufferless Deflection Mesh Router

This block is one switch of a two-dimensional mesh network on chip. It has four neighbour links (north, east, south, west) and one attached local resource. The switch holds no packet storage at all. Every packet that arrives in a cycle is registered onto an outgoing link or onto the ejection port on the next clock edge. A packet is routed to a link that brings it closer to its destination whenever one is still free. If none is free, it is deflected onto any other free link and retries from the neighbouring node.

Contention is settled by hop age, so the packet that has travelled longest is served first. A packet that has two productive links to choose from asks its neighbours how busy they are. Each switch publishes a small load figure, its stress, which counts the packets it forwarded to neighbours in the current cycle. An elaboration-time mode selects how stress is used: ignored, used as the current value, or used as a four-cycle average. The local resource may inject when the switch can still guarantee an output for every packet. It receives at most one packet per cycle that is addressed to this node.

Top module: `mesh_defl_router`

## Requirements
- R1: Every packet accepted in a cycle (a valid input on an existing link, or an accepted injection) appears exactly once on the next cycle, on one output link or on the ejection port. None is stored or dropped, and with no accepted packet every output is invalid on the next cycle.
- R2: Packet word layout from the top bit down is destination X (XW bits), destination Y (YW bits), hop age (AW bits), payload (PW bits). Every forwarded or ejected packet leaves with its age one higher, saturating at all ones, and with the other fields unchanged.
- R3: Link directions are north = Y+1, east = X+1, south = Y-1, west = X-1. A link is productive when it moves the packet toward its destination. A packet whose destination equals the node coordinates goes to the ejection port if that port is still free. Otherwise a packet takes a free productive link if one exists.
- R4: Packets are served in order of decreasing age. Equal ages are ordered by input link index, with north = 0, east = 1, south = 2 and west = 3, the lower index first. An injected packet is always served last.
- R5: When both a free X link and a free Y link are productive, the packet takes the one whose neighbour reports the lower stress. Equal stress, and the mode that ignores stress, select the X link.
- R6: At most one packet is ejected per cycle, and it is the first served packet addressed to this node. Further packets addressed to this node are deflected, and an ejected packet always carries the node's own coordinates.
- R7: The injection ready output is high exactly when the number of valid inputs on existing links, less one if any of them is addressed to this node, is below the number of existing links. An injection offered while ready is low is not taken.
- R8: A link that does not exist at the mesh boundary (north on the top row, east on the right column, south on row 0, west on column 0) never carries an output. Input valids on such a link are ignored. A packet with no free productive link is deflected to the first free existing link in index order.
- R9: In the instantaneous mode the stress output equals the number of packets currently driven on the neighbour links (0 to 4). In the mode that ignores stress it is 0.
- R10: In the averaging mode the stress output is the sum of the last four neighbour-link packet counts shifted right by two. Reset clears that history.
- R11: During and directly after reset, no output link and no ejection is valid and the stress output is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| my_x | input | XW | X coordinate of this node |
| my_y | input | YW | Y coordinate of this node |
| in_valid | input | 4 | Packet present on each incoming link (N, E, S, W) |
| in_flit | input | 4 x FW | Packet word on each incoming link |
| stress_in | input | 4 x 3 | Stress reported by each neighbour |
| inj_valid | input | 1 | Local resource offers a packet |
| inj_flit | input | FW | Packet word offered by the local resource |
| inj_ready | output | 1 | Offered packet is taken this cycle |
| out_valid | output | 4 | Packet present on each outgoing link |
| out_flit | output | 4 x FW | Packet word on each outgoing link |
| stress_out | output | 3 | Stress value sent to all neighbours |
| ej_valid | output | 1 | Packet delivered to the local resource |
| ej_flit | output | FW | Delivered packet word |

## Verification
Every cycle, the checker confirms that each accepted packet receives a grant, that the count of packets leaving equals the count that was accepted one cycle earlier, that no boundary link is ever driven, that ejected packets carry the node's coordinates, that a refused injection happens only under real link pressure, and that stress stays in range. Which link a given packet lands on cannot be seen by those properties. Age ordering, the index tie-break, the stress-driven choice between X and Y and the deflection order are shown only by the bench. It sweeps every node position of a 4 by 4 mesh with every input mask, with and without injection, and runs directed contention cases. The four-cycle averaging is also shown only by the bench's timed sequence.

// File: rtl/router_pkg.sv
package router_pkg;

  localparam int NP = 4;        // neighbour links
  localparam int NC = NP + 1;   // candidates: four links plus injection
  localparam int SW = 3;        // stress width, holds 0..4

  typedef enum logic [1:0] {
    DIR_N = 2'd0,
    DIR_E = 2'd1,
    DIR_S = 2'd2,
    DIR_W = 2'd3
  } dir_e;

  typedef enum int {
    STRESS_OFF  = 0,
    STRESS_NOW  = 1,
    STRESS_AVG4 = 2
  } stress_mode_e;

  function automatic logic [2:0] pop4(input logic [3:0] v);
    logic [2:0] s;
    s = 3'd0;
    for (int i = 0; i < 4; i++) s = s + {2'b00, v[i]};
    return s;
  endfunction

endpackage

// File: rtl/rt_rank.sv
module rt_rank #(
  parameter int AW = 4
) (
  input  logic [3:0]         valid,
  input  logic [3:0][AW-1:0] age,
  output logic [3:0][1:0]    order_idx,
  output logic [3:0]         order_v
);

  logic [3:0][2:0] rank;

  function automatic logic beats(input logic [AW-1:0] a_j, input logic [AW-1:0] a_i,
                                 input logic j_lower);
    return (a_j > a_i) || ((a_j == a_i) && j_lower);
  endfunction

  always_comb begin
    for (int i = 0; i < 4; i++) begin
      rank[i] = 3'd0;
      for (int j = 0; j < 4; j++) begin
        if (j != i && valid[j] && beats(age[j], age[i], j < i))
          rank[i] = rank[i] + 3'd1;
      end
    end
  end

  always_comb begin
    order_idx = '0;
    order_v   = '0;
    for (int k = 0; k < 4; k++) begin
      for (int i = 0; i < 4; i++) begin
        if (valid[i] && rank[i] == 3'(k)) begin
          order_idx[k] = 2'(i);
          order_v[k]   = 1'b1;
        end
      end
    end
  end

endmodule

// File: rtl/rt_alloc.sv
module rt_alloc import router_pkg::*; #(
  parameter int XW = 2,
  parameter int YW = 2
) (
  input  logic [XW-1:0]          my_x,
  input  logic [YW-1:0]          my_y,
  input  logic [NP-1:0]          port_ok,
  input  logic [NC-1:0]          cand_v,
  input  logic [NC-1:0][XW-1:0]  cand_dx,
  input  logic [NC-1:0][YW-1:0]  cand_dy,
  input  logic [NP-1:0][1:0]     order_idx,
  input  logic [NP-1:0]          order_v,
  input  logic [NP-1:0][SW-1:0]  stress_in,
  input  logic                   use_stress,
  output logic [NC-1:0]          gnt_v,
  output logic [NC-1:0][2:0]     gnt_port
);

  logic [NC-1:0]      seq_v;
  logic [NC-1:0][2:0] seq_i;

  always_comb begin
    for (int k = 0; k < NP; k++) begin
      seq_v[k] = order_v[k];
      seq_i[k] = {1'b0, order_idx[k]};
    end
    seq_v[NP] = cand_v[NP];
    seq_i[NP] = 3'(NP);
  end

  function automatic logic [2:0] choose_xy(input logic [1:0] xs, input logic [1:0] ys,
                                           input logic [SW-1:0] sx, input logic [SW-1:0] sy,
                                           input logic steer);
    return (steer && (sy < sx)) ? {1'b0, ys} : {1'b0, xs};
  endfunction

  always_comb begin
    logic [NC-1:0]   taken;
    logic [3:0]      want;
    logic [3:0]      free_p;
    logic            here;
    logic [2:0]      pick;
    logic [2:0]      ci;
    logic [1:0]      xs;
    logic [1:0]      ys;
    logic [XW-1:0]   dx;
    logic [YW-1:0]   dy;
    taken    = {1'b0, ~port_ok};
    gnt_v    = '0;
    gnt_port = '0;
    want = '0; free_p = '0; here = 1'b0; pick = 3'd7;
    ci = '0; xs = '0; ys = '0; dx = '0; dy = '0;
    for (int k = 0; k < NC; k++) begin
      if (seq_v[k]) begin
        ci   = seq_i[k];
        dx   = cand_dx[ci];
        dy   = cand_dy[ci];
        want[0] = dy > my_y;
        want[1] = dx > my_x;
        want[2] = dy < my_y;
        want[3] = dx < my_x;
        here   = (dx == my_x) && (dy == my_y);
        free_p = want & ~taken[NP-1:0];
        xs     = free_p[1] ? 2'd1 : 2'd3;
        ys     = free_p[0] ? 2'd0 : 2'd2;
        pick   = 3'd7;
        if (here && !taken[NP]) begin
          pick = 3'(NP);
        end else if ((free_p[1] | free_p[3]) && (free_p[0] | free_p[2])) begin
          pick = choose_xy(xs, ys, stress_in[xs], stress_in[ys], use_stress);
        end else if (free_p[1] | free_p[3]) begin
          pick = {1'b0, xs};
        end else if (free_p[0] | free_p[2]) begin
          pick = {1'b0, ys};
        end else begin
          for (int p = 0; p < NP; p++) begin
            if (pick == 3'd7 && !taken[p]) pick = 3'(p);
          end
        end
        if (pick != 3'd7) begin
          taken[pick]  = 1'b1;
          gnt_v[ci]    = 1'b1;
          gnt_port[ci] = pick;
        end
      end
    end
  end

endmodule

// File: rtl/rt_stress.sv
module rt_stress import router_pkg::*; #(
  parameter stress_mode_e MODE = STRESS_NOW
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [SW-1:0] cnt_d,
  output logic [SW-1:0] stress
);

  generate
    if (MODE == STRESS_OFF) begin : g_off
      logic unused_cnt;
      assign unused_cnt = ^{cnt_d, clk, rst_n};
      assign stress = '0;
    end else if (MODE == STRESS_NOW) begin : g_now
      logic [SW-1:0] cnt_q;
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
      end
      assign stress = cnt_q;
    end else begin : g_avg
      logic [3:0][SW-1:0] hist;
      logic [SW+1:0]      sum;
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) hist <= '0;
        else        hist <= {hist[2:0], cnt_d};
      end
      always_comb begin
        sum = '0;
        for (int i = 0; i < 4; i++) sum = sum + {2'b00, hist[i]};
      end
      assign stress = sum[SW+1:2];
    end
  endgenerate

endmodule

// File: rtl/mesh_defl_router.sv
module mesh_defl_router import router_pkg::*; #(
  parameter int XW     = 2,
  parameter int YW     = 2,
  parameter int AW     = 4,
  parameter int PW     = 8,
  parameter int MESH_W = 4,
  parameter int MESH_H = 4,
  parameter stress_mode_e STRESS_MODE = STRESS_NOW,
  localparam int FW    = XW + YW + AW + PW
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic [XW-1:0]         my_x,
  input  logic [YW-1:0]         my_y,
  input  logic [3:0]            in_valid,
  input  logic [3:0][FW-1:0]    in_flit,
  input  logic [3:0][2:0]       stress_in,
  input  logic                  inj_valid,
  input  logic [FW-1:0]         inj_flit,
  output logic                  inj_ready,
  output logic [3:0]            out_valid,
  output logic [3:0][FW-1:0]    out_flit,
  output logic [2:0]            stress_out,
  output logic                  ej_valid,
  output logic [FW-1:0]         ej_flit
);

  function automatic logic [XW-1:0] f_dx(input logic [FW-1:0] f);
    return f[FW-1 -: XW];
  endfunction
  function automatic logic [YW-1:0] f_dy(input logic [FW-1:0] f);
    return f[PW+AW +: YW];
  endfunction
  function automatic logic [AW-1:0] f_age(input logic [FW-1:0] f);
    return f[PW +: AW];
  endfunction
  function automatic logic [FW-1:0] hop(input logic [FW-1:0] f);
    logic [FW-1:0] r;
    r = f;
    if (!(&f[PW +: AW])) r[PW +: AW] = f[PW +: AW] + 1'b1;
    return r;
  endfunction

  // boundary: which links physically exist
  logic [NP-1:0] port_ok;
  always_comb begin
    port_ok[DIR_N] = int'(my_y) != MESH_H - 1;
    port_ok[DIR_E] = int'(my_x) != MESH_W - 1;
    port_ok[DIR_S] = my_y != '0;
    port_ok[DIR_W] = my_x != '0;
  end

  logic [NP-1:0]         in_ok;
  logic [NP-1:0][AW-1:0] in_age;
  logic                  here_hit;
  logic [2:0]            n_transit;
  logic [2:0]            n_ports;
  logic [2:0]            occ;
  logic [NC-1:0]         cand_v;
  logic [NC-1:0][FW-1:0] cand_f;
  logic [NC-1:0][XW-1:0] cand_dx;
  logic [NC-1:0][YW-1:0] cand_dy;
  logic [2:0]            n_in;

  assign in_ok     = in_valid & port_ok;
  assign n_transit = pop4(in_ok);
  assign n_ports   = pop4(port_ok);

  always_comb begin
    here_hit = 1'b0;
    for (int i = 0; i < NP; i++) begin
      in_age[i] = f_age(in_flit[i]);
      if (in_ok[i] && f_dx(in_flit[i]) == my_x && f_dy(in_flit[i]) == my_y)
        here_hit = 1'b1;
    end
  end

  assign occ       = n_transit - {2'b00, here_hit};
  assign inj_ready = occ < n_ports;
  assign cand_v    = {inj_valid & inj_ready, in_ok};
  assign cand_f    = {inj_flit, in_flit};
  assign n_in      = n_transit + {2'b00, cand_v[NP]};

  always_comb begin
    for (int c = 0; c < NC; c++) begin
      cand_dx[c] = f_dx(cand_f[c]);
      cand_dy[c] = f_dy(cand_f[c]);
    end
  end

  logic [NP-1:0][1:0] order_idx;
  logic [NP-1:0]      order_v;

  rt_rank #(.AW(AW)) rank_i (
    .valid     (in_ok),
    .age       (in_age),
    .order_idx (order_idx),
    .order_v   (order_v)
  );

  logic [NC-1:0]      gnt_v;
  logic [NC-1:0][2:0] gnt_port;

  rt_alloc #(.XW(XW), .YW(YW)) alloc_i (
    .my_x       (my_x),
    .my_y       (my_y),
    .port_ok    (port_ok),
    .cand_v     (cand_v),
    .cand_dx    (cand_dx),
    .cand_dy    (cand_dy),
    .order_idx  (order_idx),
    .order_v    (order_v),
    .stress_in  (stress_in),
    .use_stress (STRESS_MODE != STRESS_OFF),
    .gnt_v      (gnt_v),
    .gnt_port   (gnt_port)
  );

  // output crossbar, index NP is the ejection port
  logic [NC-1:0]         nxt_v;
  logic [NC-1:0][FW-1:0] nxt_f;
  always_comb begin
    nxt_v = '0;
    nxt_f = '0;
    for (int o = 0; o < NC; o++) begin
      for (int c = 0; c < NC; c++) begin
        if (gnt_v[c] && gnt_port[c] == 3'(o)) begin
          nxt_v[o] = 1'b1;
          nxt_f[o] = hop(cand_f[c]);
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid <= '0;
      out_flit  <= '0;
      ej_valid  <= 1'b0;
      ej_flit   <= '0;
    end else begin
      out_valid <= nxt_v[NP-1:0];
      out_flit  <= nxt_f[NP-1:0];
      ej_valid  <= nxt_v[NP];
      ej_flit   <= nxt_f[NP];
    end
  end

  rt_stress #(.MODE(STRESS_MODE)) stress_i (
    .clk    (clk),
    .rst_n  (rst_n),
    .cnt_d  (pop4(nxt_v[NP-1:0])),
    .stress (stress_out)
  );

endmodule

// File: rtl/mesh_defl_router_chk.sv
module mesh_defl_router_chk #(
  parameter int XW     = 2,
  parameter int YW     = 2,
  parameter int MESH_W = 4,
  parameter int MESH_H = 4
) (
  input logic          clk,
  input logic          rst_n,
  input logic [XW-1:0] my_x,
  input logic [YW-1:0] my_y,
  input logic [3:0]    in_valid,
  input logic          inj_valid,
  input logic          inj_ready,
  input logic [3:0]    out_valid,
  input logic          ej_valid,
  input logic [XW-1:0] ej_dx,
  input logic [YW-1:0] ej_dy,
  input logic [2:0]    stress_out,
  input logic [4:0]    cand_v,
  input logic [4:0]    gnt_v,
  input logic [2:0]    n_in
);

  function automatic logic [3:0] links_at(input logic [XW-1:0] x, input logic [YW-1:0] y);
    logic [3:0] e;
    e[0] = int'(y) < MESH_H - 1;
    e[1] = int'(x) < MESH_W - 1;
    e[2] = int'(y) > 0;
    e[3] = int'(x) > 0;
    return e;
  endfunction

  // R1
  grant_all_chk: assert property (@(posedge clk) disable iff (!rst_n)
    gnt_v == cand_v);

  // R1
  conserve_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cand_v != 5'd0 |=> ($countones(out_valid) + int'(ej_valid)) == int'($past(n_in)));

  // R1
  idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cand_v == 5'd0 |=> (out_valid == 4'd0) && !ej_valid);

  // R8
  no_edge_link_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid != 4'd0 |-> (out_valid & ~links_at($past(my_x), $past(my_y))) == 4'd0);

  // R6
  eject_here_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ej_valid |-> (ej_dx == $past(my_x)) && (ej_dy == $past(my_y)));

  // R7
  refuse_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (inj_valid && !inj_ready) |-> $countones(in_valid) >= 2);

  // R9
  stress_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    stress_out <= 3'd4);

endmodule

bind mesh_defl_router mesh_defl_router_chk #(
  .XW(XW), .YW(YW), .MESH_W(MESH_W), .MESH_H(MESH_H)
) chk_i (
  .clk        (clk),
  .rst_n      (rst_n),
  .my_x       (my_x),
  .my_y       (my_y),
  .in_valid   (in_valid),
  .inj_valid  (inj_valid),
  .inj_ready  (inj_ready),
  .out_valid  (out_valid),
  .ej_valid   (ej_valid),
  .ej_dx      (ej_flit[FW-1 -: XW]),
  .ej_dy      (ej_flit[PW+AW +: YW]),
  .stress_out (stress_out),
  .cand_v     (cand_v),
  .gnt_v      (gnt_v),
  .n_in       (n_in)
);

// File: tb/mesh_defl_router_tb_top.sv
module mesh_defl_router_tb_top;

  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic             rst_n;
  logic [1:0]       mx, my;
  logic [3:0]       iv;
  logic [3:0][15:0] ifl;
  logic [3:0][2:0]  sin;
  logic             jv;
  logic [15:0]      jfl;

  logic             jr, jr_a, jr_n;
  logic [3:0]       ov, ov_a, ov_n;
  logic [3:0][15:0] ofl, ofl_a, ofl_n;
  logic [2:0]       sout, sout_a, sout_n;
  logic             ev, ev_a, ev_n;
  logic [15:0]      efl, efl_a, efl_n;

  mesh_defl_router #(.STRESS_MODE(router_pkg::STRESS_NOW)) dut_i (
    .clk(clk), .rst_n(rst_n), .my_x(mx), .my_y(my), .in_valid(iv), .in_flit(ifl),
    .stress_in(sin), .inj_valid(jv), .inj_flit(jfl), .inj_ready(jr),
    .out_valid(ov), .out_flit(ofl), .stress_out(sout), .ej_valid(ev), .ej_flit(efl));

  mesh_defl_router #(.STRESS_MODE(router_pkg::STRESS_AVG4)) dut_avg_i (
    .clk(clk), .rst_n(rst_n), .my_x(mx), .my_y(my), .in_valid(iv), .in_flit(ifl),
    .stress_in(sin), .inj_valid(jv), .inj_flit(jfl), .inj_ready(jr_a),
    .out_valid(ov_a), .out_flit(ofl_a), .stress_out(sout_a), .ej_valid(ev_a), .ej_flit(efl_a));

  mesh_defl_router #(.STRESS_MODE(router_pkg::STRESS_OFF)) dut_off_i (
    .clk(clk), .rst_n(rst_n), .my_x(mx), .my_y(my), .in_valid(iv), .in_flit(ifl),
    .stress_in(sin), .inj_valid(jv), .inj_flit(jfl), .inj_ready(jr_n),
    .out_valid(ov_n), .out_flit(ofl_n), .stress_out(sout_n), .ej_valid(ev_n), .ej_flit(efl_n));

  int total = 0;
  int bad   = 0;
  logic [15:0] lfsr = 16'hACE1;

  task automatic check(input string req, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s act=%0d exp=%0d", req, act, exp);
    end
  endtask

  function automatic logic [15:0] mk(input int dx, input int dy, input int age, input int pay);
    return {2'(dx), 2'(dy), 4'(age), 8'(pay)};
  endfunction

  function automatic int cnt4(input logic [3:0] v);
    return int'(v[0]) + int'(v[1]) + int'(v[2]) + int'(v[3]);
  endfunction

  function automatic logic [3:0] links(input int x, input int y);
    return {x != 0, y != 0, x != 3, y != 3};
  endfunction

  function automatic logic toward(input int o, input int dx, input int dy, input int x, input int y);
    case (o)
      0: return dy > y;
      1: return dx > x;
      2: return dy < y;
      default: return dx < x;
    endcase
  endfunction

  task automatic rnd();
    lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
  endtask

  task automatic clear_in();
    iv = '0; ifl = '0; jv = 1'b0; jfl = '0; sin = '0;
  endtask

  task automatic tick();
    @(posedge clk);
    #1;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    total++;
    bad++;
    $display("FAIL watchdog act=hung exp=done");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    rst_n = 1'b0;
    mx = 2'd1; my = 2'd1;
    clear_in();
    repeat (3) @(posedge clk);
    #1;
    // R11 reset state
    check("R11 out_valid", int'(ov), 0);
    check("R11 ej_valid", int'(ev), 0);
    check("R11 stress", int'(sout) + int'(sout_a), 0);
    rst_n = 1'b1;
    #1;
    check("R7 ready idle", int'(jr), 1);
    tick();
    check("R11 after reset", int'(ov) + int'(ev), 0);

    // R3 R2 single packet west->east
    iv = 4'b1000; ifl[3] = mk(3, 1, 0, 8'h5A);
    tick(); clear_in();
    check("R3 east link", int'(ov), 4'b0010);
    check("R2 word", int'(ofl[1]), int'(mk(3, 1, 1, 8'h5A)));

    // R2 saturation
    iv = 4'b1000; ifl[3] = mk(3, 1, 15, 8'h11);
    tick(); clear_in();
    check("R2 age saturates", int'(ofl[1][11:8]), 15);

    // R3 ejection
    iv = 4'b0001; ifl[0] = mk(1, 1, 2, 8'h3C);
    tick(); clear_in();
    check("R3 eject valid", int'(ev), 1);
    check("R3 eject payload", int'(efl[7:0]), 8'h3C);
    check("R3 no link use", int'(ov), 0);

    // R6 two for this node
    iv = 4'b0101; ifl[0] = mk(1, 1, 2, 8'hC1); ifl[2] = mk(1, 1, 5, 8'hC2);
    tick(); clear_in();
    check("R6 older ejected", int'(efl[7:0]), 8'hC2);
    check("R6 other deflected", int'(ov), 4'b0001);
    check("R6 deflected payload", int'(ofl[0][7:0]), 8'hC1);

    // R4 oldest wins
    iv = 4'b0101; ifl[0] = mk(3, 1, 1, 8'hB1); ifl[2] = mk(3, 1, 4, 8'hB2);
    tick(); clear_in();
    check("R4 oldest on east", int'(ofl[1][7:0]), 8'hB2);
    check("R8 deflect first free", int'(ofl[0][7:0]), 8'hB1);

    // R4 equal age
    iv = 4'b0101; ifl[0] = mk(3, 1, 2, 8'hA1); ifl[2] = mk(3, 1, 2, 8'hA2);
    tick(); clear_in();
    check("R4 tie lower index", int'(ofl[1][7:0]), 8'hA1);
    check("R4 tie loser", int'(ofl[0][7:0]), 8'hA2);

    // R5 stress steering
    iv = 4'b1000; ifl[3] = mk(2, 2, 0, 8'h01); sin[0] = 3'd3; sin[1] = 3'd1;
    tick(); clear_in();
    check("R5 low stress east", int'(ov), 4'b0010);
    iv = 4'b1000; ifl[3] = mk(2, 2, 0, 8'h02); sin[0] = 3'd1; sin[1] = 3'd3;
    tick(); clear_in();
    check("R5 low stress north", int'(ov), 4'b0001);
    check("R5 off mode x", int'(ov_n), 4'b0010);
    iv = 4'b1000; ifl[3] = mk(2, 2, 0, 8'h03); sin[0] = 3'd2; sin[1] = 3'd2;
    tick(); clear_in();
    check("R5 equal stress x", int'(ov), 4'b0010);

    // R9 instantaneous stress
    iv = 4'b0111; ifl[0] = mk(3, 3, 0, 1); ifl[1] = mk(3, 3, 0, 2); ifl[2] = mk(3, 3, 0, 3);
    tick(); clear_in();
    check("R9 stress three", int'(sout), 3);
    check("R9 off mode zero", int'(sout_n), 0);
    tick();
    check("R9 stress idle", int'(sout), 0);

    // R10 averaging, R7 refused injection
    repeat (4) tick();
    iv = 4'b1111;
    for (int i = 0; i < 4; i++) ifl[i] = mk(3, 3, i, 8'h20 + i);
    jv = 1'b1; jfl = mk(1, 1, 0, 8'h77);
    #1;
    check("R7 ready low", int'(jr), 0);
    tick(); clear_in();
    check("R7 refused no eject", int'(ev), 0);
    check("R9 stress four", int'(sout), 4);
    check("R10 avg step0", int'(sout_a), 1);
    for (int k = 1; k < 4; k++) begin
      tick();
      check("R10 avg held", int'(sout_a), 1);
    end
    tick();
    check("R10 avg cleared", int'(sout_a), 0);

    // R7 accepted injection with one local packet
    iv = 4'b1111;
    ifl[0] = mk(1, 1, 3, 8'h30);
    for (int i = 1; i < 4; i++) ifl[i] = mk(3, 3, i, 8'h30 + i);
    jv = 1'b1; jfl = mk(0, 1, 0, 8'h55);
    #1;
    check("R7 ready high", int'(jr), 1);
    tick(); clear_in();
    begin
      int hit = 0;
      for (int o = 0; o < 4; o++)
        if (ov[o] && ofl[o][7:0] == 8'h55 && ofl[o][11:8] == 4'd1) hit = 1;
      check("R7 injected forwarded", hit, 1);
      check("R7 all links used", int'(ov), 4'b1111);
    end

    // R8 corner node
    mx = 2'd0; my = 2'd0;
    iv = 4'b1111;
    for (int i = 0; i < 4; i++) ifl[i] = mk(3, 3, i + 1, 8'h40 + i);
    jv = 1'b1; jfl = mk(3, 0, 0, 8'h66);
    #1;
    check("R7 corner ready", int'(jr), 0);
    tick(); clear_in();
    check("R8 no boundary link", int'(ov & 4'b1100), 0);
    check("R8 two links used", cnt4(ov), 2);

    // sweep: every node, every input mask, with and without injection
    for (int n = 0; n < 16; n++) begin
      for (int m = 0; m < 16; m++) begin
        for (int inj = 0; inj < 2; inj++) begin
          int x, y, nv, here, exp_cnt, old_i, old_age, age_bad, ok;
          logic [3:0] ex;
          int src_age[5];
          int src_dx[5];
          int src_dy[5];
          x = n % 4; y = n / 4;
          mx = 2'(x); my = 2'(y);
          ex = links(x, y);
          iv = 4'(m);
          nv = 0; here = 0; old_i = -1; old_age = -1;
          for (int i = 0; i < 4; i++) begin
            rnd();
            src_dx[i] = int'(lfsr[1:0]); src_dy[i] = int'(lfsr[3:2]);
            src_age[i] = ((i + m) % 4) * 3 + 1;
            sin[i] = 3'(lfsr[6:4] % 5);
            ifl[i] = mk(src_dx[i], src_dy[i], src_age[i], i);
            if (iv[i] && ex[i]) begin
              nv++;
              if (src_dx[i] == x && src_dy[i] == y) here = 1;
              if (src_age[i] > old_age) begin old_age = src_age[i]; old_i = i; end
            end
          end
          rnd();
          src_dx[4] = int'(lfsr[1:0]); src_dy[4] = int'(lfsr[3:2]); src_age[4] = 0;
          jv = 1'(inj); jfl = mk(src_dx[4], src_dy[4], 0, 4);
          #1;
          check("R7 sweep ready", int'(jr), int'((nv - here) < cnt4(ex)));
          exp_cnt = nv + int'(jv && jr);
          tick(); clear_in();
          check("R1 sweep conserve", cnt4(ov) + int'(ev), exp_cnt);
          check("R8 sweep boundary", int'(ov & ~ex), 0);
          age_bad = 0;
          for (int o = 0; o < 4; o++) begin
            if (ov[o]) begin
              int p;
              p = int'(ofl[o][7:0]);
              if (p > 4) age_bad++;
              else if (int'(ofl[o][11:8]) != src_age[p] + 1) age_bad++;
            end
          end
          if (ev) begin
            int p;
            p = int'(efl[7:0]);
            if (p > 4) age_bad++;
            else if (int'(efl[11:8]) != src_age[p] + 1) age_bad++;
            check("R6 sweep eject here", int'(efl[15:12]), x * 4 + y);
          end
          check("R2 sweep ages", age_bad, 0);
          if (old_i >= 0) begin
            ok = 0;
            if (src_dx[old_i] == x && src_dy[old_i] == y)
              ok = int'(ev && efl[7:0] == 8'(old_i));
            else
              for (int o = 0; o < 4; o++)
                if (ov[o] && ofl[o][7:0] == 8'(old_i) &&
                    toward(o, src_dx[old_i], src_dy[old_i], x, y)) ok = 1;
            check("R3 R4 oldest productive", ok, 1);
          end
        end
      end
    end

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule